// File: doc/BRIEF.md
# Alarm Match Interrupt Unit

This block watches the running time of a calendar counter and raises an alarm when the current minute, hour and third calendar field agree with three programmed alarm registers. The calendar counter supplies the minute and hour in BCD, the weekday as a one-hot vector, the day of month in BCD, and a single-cycle pulse at each minute rollover. The comparison is made only on that pulse, so each matching minute produces exactly one alarm event.

Each alarm register has a disable bit in bit 7. A field with that bit set is left out of the comparison. A mode bit in the control register selects how the third alarm register is read. In weekday mode it is a mask of days. In date mode it is a BCD day of month. An alarm event sets a sticky flag. The flag drives the active-low interrupt request only while the interrupt enable bit is set. The host clears the flag by writing 0 to it.

A two-state machine handles event timing. In state `S_WAIT`, a minute pulse whose comparison succeeds takes the transition `WAIT->SET`. A pulse without a match takes `WAIT->WAIT`. In state `S_SET` the flag is raised, and the machine takes `SET->WAIT`, or `SET->SET` if another matching pulse arrives at once.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, the minute, hour and weekday/date alarm registers (addresses 0, 1, 2) read 0x80 and the control register (address 3) reads 0x00. The interrupt request `irq_n` is 1.
- R2: Writes are accepted when `wr_en` is high and are visible on `rd_data` at the following cycle. Minute (address 0) and weekday/date (address 2) store all 8 bits. Hour (address 1) stores bit 7 and bits 5:0, and bit 6 reads 0. Control (address 3) holds the flag in bit 0, the interrupt enable in bit 1 and the date-mode select in bit 2. Bits 7:3 of the control register read 0.
- R3: When a minute pulse is sampled and every field with bit 7 at 0 matches, the flag (control bit 0) reads 1 after the second rising edge following the pulse's cycle. The minute field matches when alarm bits 6:0 equal the minute. The hour field matches when alarm bits 5:0 equal the hour.
- R4: A field whose alarm bit 7 is 1 takes no part in the comparison. If all three fields have bit 7 set, every minute pulse raises the flag.
- R5: With control bit 2 at 0 (weekday mode), the third field matches when alarm bits 6:0 and the one-hot weekday input share at least one set bit.
- R6: With control bit 2 at 1 (date mode), the third field matches when alarm bits 5:0 equal the BCD day of month.
- R7: Without a minute pulse, the flag does not change, even when the time inputs match the alarm.
- R8: `irq_n` is 0 exactly while the flag is 1 and the interrupt enable (control bit 1) is 1. A new event still sets the flag while the enable is 0.
- R9: Writing the control register with bit 0 at 0 clears the flag, and this releases `irq_n`. Writing with bit 0 at 1 leaves the flag unchanged.
- R10: If a flag-clearing write lands in the same cycle in which an alarm event raises the flag, the flag still ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_tick | input | 1 | One-cycle pulse at each minute rollover |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_wday | input | 7 | Current weekday, one-hot |
| cur_day | input | 6 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register readback (combinational) |
| irq_n | output | 1 | Active-low alarm interrupt request |

## Verification
Two functions can fall in the same cycle: a host write that clears the flag, and the `S_SET` cycle in which an alarm event raises the flag. The bench provokes this by issuing a matching minute pulse and then placing a control-register write with bit 0 at 0 in the very next cycle. It judges the result by reading back a flag of 1 and a low `irq_n`. A following clear write must then release both. Random trials mix the disable bits, both third-field modes and both enable settings. Each trial is compared against a bench model of the match rules.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int WDAY_W = 7;
    localparam int DAY_W  = 6;
    localparam int AE_BIT = REG_W - 1;

    localparam int CTRL_FLAG = 0;
    localparam int CTRL_IEN  = 1;
    localparam int CTRL_DATE = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MIN  = 2'd0,
        ADDR_HOUR = 2'd1,
        ADDR_WDAY = 2'd2,
        ADDR_CTRL = 2'd3
    } reg_addr_e;

    typedef enum logic {
        S_WAIT = 1'b0,
        S_SET  = 1'b1
    } alarm_state_e;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                af,
    output logic                min_off,
    output logic [MIN_W-1:0]    min_val,
    output logic                hour_off,
    output logic [HOUR_W-1:0]   hour_val,
    output logic                wd_off,
    output logic [WDAY_W-1:0]   wd_val,
    output logic                ien,
    output logic                date_mode,
    output logic                clr_req,
    output logic [REG_W-1:0]    rd_data
);
    localparam int HOUR_PAD = REG_W - 1 - HOUR_W;
    localparam int CTRL_PAD = REG_W - 3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_off   <= 1'b1;
            min_val   <= '0;
            hour_off  <= 1'b1;
            hour_val  <= '0;
            wd_off    <= 1'b1;
            wd_val    <= '0;
            ien       <= 1'b0;
            date_mode <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                ADDR_MIN: begin
                    min_off <= wr_data[AE_BIT];
                    min_val <= wr_data[MIN_W-1:0];
                end
                ADDR_HOUR: begin
                    hour_off <= wr_data[AE_BIT];
                    hour_val <= wr_data[HOUR_W-1:0];
                end
                ADDR_WDAY: begin
                    wd_off <= wr_data[AE_BIT];
                    wd_val <= wr_data[WDAY_W-1:0];
                end
                ADDR_CTRL: begin
                    ien       <= wr_data[CTRL_IEN];
                    date_mode <= wr_data[CTRL_DATE];
                end
            endcase
        end
    end

    assign clr_req = wr_en && (reg_addr_e'(wr_addr) == ADDR_CTRL) && !wr_data[CTRL_FLAG];

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            ADDR_MIN:  rd_data = {min_off, min_val};
            ADDR_HOUR: rd_data = {hour_off, {HOUR_PAD{1'b0}}, hour_val};
            ADDR_WDAY: rd_data = {wd_off, wd_val};
            ADDR_CTRL: rd_data = {{CTRL_PAD{1'b0}}, date_mode, ien, af};
        endcase
    end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_pkg::*;
(
    input  logic                min_off,
    input  logic [MIN_W-1:0]    min_val,
    input  logic                hour_off,
    input  logic [HOUR_W-1:0]   hour_val,
    input  logic                wd_off,
    input  logic [WDAY_W-1:0]   wd_val,
    input  logic                date_mode,
    input  logic [MIN_W-1:0]    cur_min,
    input  logic [HOUR_W-1:0]   cur_hour,
    input  logic [WDAY_W-1:0]   cur_wday,
    input  logic [DAY_W-1:0]    cur_day,
    output logic                hit
);
    logic min_ok, hour_ok, third_ok;

    always_comb begin
        min_ok  = min_off  || (min_val  == cur_min);
        hour_ok = hour_off || (hour_val == cur_hour);
        if (date_mode)
            third_ok = wd_off || (wd_val[DAY_W-1:0] == cur_day);
        else
            third_ok = wd_off || ((wd_val & cur_wday) != '0);
        hit = min_ok && hour_ok && third_ok;
    end
endmodule

// File: rtl/alarm_fsm.sv
module alarm_fsm
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic min_tick,
    input  logic hit,
    input  logic clr_req,
    output logic in_set,
    output logic af
);
    alarm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT: if (min_tick && hit) state_d = S_SET;
            S_SET:  state_d = (min_tick && hit) ? S_SET : S_WAIT;
        endcase
    end

    assign in_set = (state_q == S_SET);

    always_ff @(posedge clk) begin
        if (!rst_n)       af <= 1'b0;
        else if (in_set)  af <= 1'b1;
        else if (clr_req) af <= 1'b0;
    end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                min_tick,
    input  logic [MIN_W-1:0]    cur_min,
    input  logic [HOUR_W-1:0]   cur_hour,
    input  logic [WDAY_W-1:0]   cur_wday,
    input  logic [DAY_W-1:0]    cur_day,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [REG_W-1:0]    rd_data,
    output logic                irq_n
);
    logic                min_off, hour_off, wd_off;
    logic [MIN_W-1:0]    min_val;
    logic [HOUR_W-1:0]   hour_val;
    logic [WDAY_W-1:0]   wd_val;
    logic                ien, date_mode, clr_req, hit, in_set, af;

    alarm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .af(af),
        .min_off(min_off), .min_val(min_val), .hour_off(hour_off),
        .hour_val(hour_val), .wd_off(wd_off), .wd_val(wd_val),
        .ien(ien), .date_mode(date_mode), .clr_req(clr_req), .rd_data(rd_data)
    );

    alarm_cmp u_cmp (
        .min_off(min_off), .min_val(min_val), .hour_off(hour_off),
        .hour_val(hour_val), .wd_off(wd_off), .wd_val(wd_val),
        .date_mode(date_mode), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_day(cur_day), .hit(hit)
    );

    alarm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .hit(hit),
        .clr_req(clr_req), .in_set(in_set), .af(af)
    );

    assign irq_n = !(af && ien);
endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic min_tick,
    input logic in_set,
    input logic clr_req,
    input logic af,
    input logic irq_n
);
    assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> $past(in_set));

    assert_set_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_set) |-> $past(min_tick));

    assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !in_set) |=> !af);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_set |=> af);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> af);
endmodule

bind alarm_match_unit alarm_match_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .in_set(in_set),
    .clr_req(clr_req), .af(af), .irq_n(irq_n)
);

// File: tb/alarm_match_unit_tb.sv
module alarm_match_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       min_tick = 1'b0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [6:0] cur_wday = 7'b0000001;
    logic [5:0] cur_day = 6'h01;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alarm_match_unit u_dut (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_wday(cur_wday), .cur_day(cur_day),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic bit model_hit(logic [7:0] am, logic [7:0] ah, logic [7:0] aw,
                                     bit dmode, logic [6:0] cm, logic [5:0] ch,
                                     logic [6:0] cw, logic [5:0] cd);
        bit m, h, t;
        m = am[7] || (am[6:0] == cm);
        h = ah[7] || (ah[5:0] == ch);
        if (dmode) t = aw[7] || (aw[5:0] == cd);
        else       t = aw[7] || ((aw[6:0] & cw) != 0);
        return m && h && t;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // pulse tick for one cycle, then wait for the flag to settle
    task automatic tick_and_wait();
        @(negedge clk);
        min_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        min_tick = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int wd = 0;
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); check("R1 min", d, 8'h80);
        rd(2'd1, d); check("R1 hour", d, 8'h80);
        rd(2'd2, d); check("R1 wday", d, 8'h80);
        rd(2'd3, d); check("R1 ctrl", d, 8'h00);
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);

        // R2 readback and reserved bits
        wr(2'd0, 8'h59); rd(2'd0, d); check("R2 min", d, 8'h59);
        wr(2'd1, 8'hFF); rd(2'd1, d); check("R2 hour bit6", d, 8'hBF);
        wr(2'd2, 8'h7F); rd(2'd2, d); check("R2 wday", d, 8'h7F);
        wr(2'd3, 8'hFE); rd(2'd3, d); check("R2 ctrl", d, 8'h06);

        // R4 all fields disabled: every tick fires
        wr(2'd0, 8'h80); wr(2'd1, 8'h80); wr(2'd2, 8'h80); wr(2'd3, 8'h02);
        cur_min = 7'h12; cur_hour = 6'h03;
        tick_and_wait();
        rd(2'd3, d); check("R4 all off fires", d, 8'h03);
        check("R8 irq low", {7'b0, irq_n}, 8'h00);

        // R9 write 1 keeps, write 0 clears
        wr(2'd3, 8'h03); rd(2'd3, d); check("R9 keep", d, 8'h03);
        wr(2'd3, 8'h02); rd(2'd3, d); check("R9 clear", d, 8'h02);
        check("R9 irq released", {7'b0, irq_n}, 8'h01);

        // R3 / R7 match without tick does nothing
        wr(2'd0, 8'h30); wr(2'd1, 8'h21); wr(2'd2, 8'h80);
        cur_min = 7'h30; cur_hour = 6'h21;
        repeat (5) @(negedge clk);
        rd(2'd3, d); check("R7 no tick", d, 8'h02);
        tick_and_wait();
        rd(2'd3, d); check("R3 min hour match", d, 8'h03);

        // R10 clear in same cycle as event
        wr(2'd3, 8'h02);
        @(negedge clk); min_tick = 1'b1;
        @(posedge clk);
        @(negedge clk); min_tick = 1'b0;
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h02;
        @(posedge clk);
        @(negedge clk); wr_en = 1'b0;
        rd(2'd3, d); check("R10 set wins", d, 8'h03);
        check("R10 irq", {7'b0, irq_n}, 8'h00);
        wr(2'd3, 8'h02); rd(2'd3, d); check("R10 later clear", d, 8'h02);

        // R5 weekday mask, R6 date
        wr(2'd0, 8'h80); wr(2'd1, 8'h80);
        wr(2'd2, 8'h14); cur_wday = 7'b0000100;
        tick_and_wait(); rd(2'd3, d); check("R5 mask hit", d, 8'h03);
        wr(2'd3, 8'h02); cur_wday = 7'b0001000;
        tick_and_wait(); rd(2'd3, d); check("R5 mask miss", d, 8'h02);
        wr(2'd2, 8'h14); wr(2'd3, 8'h06); cur_day = 6'h14;
        tick_and_wait(); rd(2'd3, d); check("R6 date hit", d, 8'h07);
        wr(2'd3, 8'h04); cur_day = 6'h15;
        tick_and_wait(); rd(2'd3, d); check("R6 date miss, R8 ien off", d, 8'h04);
        check("R8 irq off", {7'b0, irq_n}, 8'h01);

        // random trials
        for (int i = 0; i < 300; i++) begin
            logic [7:0] am, ah, aw;
            bit dm, ie, e;
            int mi, hr, dy, wdi;
            mi = int'($urandom_range(0, 59)); hr = int'($urandom_range(0, 23));
            dy = int'($urandom_range(1, 31)); wdi = int'($urandom_range(0, 6));
            dm = 1'($urandom_range(0, 1)); ie = 1'($urandom_range(0, 1));
            cur_min = to_bcd(mi)[6:0]; cur_hour = to_bcd(hr)[5:0];
            cur_day = to_bcd(dy)[5:0]; cur_wday = 7'(1 << wdi);
            am = ($urandom_range(0, 1) != 0) ? {1'b0, cur_min} : {1'b0, to_bcd(int'($urandom_range(0, 59)))[6:0]};
            ah = ($urandom_range(0, 1) != 0) ? {2'b0, cur_hour} : {2'b0, to_bcd(int'($urandom_range(0, 23)))[5:0]};
            if (dm) aw = ($urandom_range(0, 1) != 0) ? {2'b0, cur_day} : {2'b0, to_bcd(int'($urandom_range(1, 31)))[5:0]};
            else    aw = {1'b0, 7'($urandom_range(0, 127))};
            if ($urandom_range(0, 3) == 0) am[7] = 1'b1;
            if ($urandom_range(0, 3) == 0) ah[7] = 1'b1;
            if ($urandom_range(0, 3) == 0) aw[7] = 1'b1;
            wr(2'd0, am); wr(2'd1, ah); wr(2'd2, aw);
            wr(2'd3, {5'b0, dm, ie, 1'b0});
            tick_and_wait();
            e = model_hit(am, ah, aw, dm, cur_min, cur_hour, cur_wday, cur_day);
            rd(2'd3, d);
            check(dm ? "R6 R3 random" : "R5 R3 random", d, {5'b0, dm, ie, e});
            check("R8 random irq", {7'b0, irq_n}, {7'b0, !(e && ie)});
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule